// File: doc/BRIEF.md
# Dual-Length Bus Output Controller

This block is the control side of a packet transmitter that sits on a shared bus. The transmitter has two buffers. One holds packets that take two bus cycles: a header state followed by one data state. The other holds packets that take five bus cycles: a header state followed by four data states. Local logic fills a buffer and then pulses an arm input. The block then places a request code for the arbiter on its request output and marks the buffer busy.

When the arbiter answers with a grant and a length bit, the block walks a fixed sequence of data states for that length. It drives the lane selects for header or data and for the short or long buffer. It also drives an advance strobe that moves the long buffer forward. A buffer is released only by a completed transfer of its own length that was granted while the buffer was already armed. An arm that lands inside a transfer is never mistaken for that transfer's payload.

The arbiter, the data path and the buffer storage live elsewhere. Only the sequencing state and the per-buffer flags are built here.

Top module: `dual_len_bus_tx_ctl`

## Requirements
- R1: Once reset has been held high for at least RST_CYCLES (default 5) clock cycles, and for as long as it stays high, the outputs read req_code 0, hdr_out 0, sel_hdr 1, short_busy 0, long_busy 0 and adv_long 0, whatever grant and the arm inputs do.
- R2: A grant is taken only in the idle state. A grant with grant_len 0 gives one data state, and a grant with grant_len 1 gives four data states in order. Each transfer then returns to idle for at least one cycle, so a grant held high alternates the data states with one idle cycle. sel_hdr is 1 in idle and 0 in every data state.
- R3: In idle, sel_long equals grant_len combinationally. In a data state, sel_long holds the length taken with the grant and ignores grant_len.
- R4: In the cycle an idle short buffer is armed, req_code is 3. In the cycle an idle long buffer is armed, req_code is 2. The matching busy flag reads 1 from the next cycle on.
- R5: When both buffers are armed in the same cycle, req_code is 3 in that cycle, 2 in the next and 0 after that. Both busy flags are set from the next cycle on.
- R6: hdr_out is 1 only in idle, and only when the buffer named by the current sel_long is busy. With both buffers busy it is 1 for either value of grant_len.
- R7: short_busy is cleared only when a short transfer completes, and a long transfer leaves it set. In the same way, long_busy is cleared only when a long transfer completes.
- R8: A transfer clears a busy flag only if that buffer was already busy in the cycle the grant was taken. An arm in the grant cycle or in any data state leaves the flag set, and the next matching transfer clears it.
- R9: adv_long is 1 in the first three of the four long data states when long_busy was set at the grant cycle. It is 0 in the fourth data state, in idle, and whenever the long buffer was not armed before the grant.
- R10: An arm pulse for a buffer that is already busy produces no request code and leaves the busy flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| grant | input | 1 | Bus grant from the arbiter |
| grant_len | input | 1 | Granted length: 0 short, 1 long |
| arm_short | input | 1 | Short buffer has been filled |
| arm_long | input | 1 | Long buffer has been filled |
| req_code | output | 2 | Request to arbiter: 0 none, 3 short, 2 long |
| hdr_out | output | 1 | A header is ready to drive in idle |
| sel_hdr | output | 1 | Header lane selected (idle) |
| sel_long | output | 1 | Long buffer lane selected |
| short_busy | output | 1 | Short buffer armed and not yet sent |
| long_busy | output | 1 | Long buffer armed and not yet sent |
| adv_long | output | 1 | Advance strobe for the long buffer |

## Verification
The hardest situation to reach is an arm that coincides with a transfer already under way. The busy flag then reads 1 at the ports, but the transfer in progress must not release it. The bench times arm pulses onto the grant cycle and onto a middle long data state. It then checks that the flag survives the end of that transfer, that adv_long stays low during it, and that the following matching transfer both advances and releases the buffer.

// File: rtl/dlo_pkg.sv
package dlo_pkg;

   typedef enum logic {
      LEN_SHORT = 1'b0,
      LEN_LONG  = 1'b1
   } len_e;

   localparam int NUM_BUFS = 2;

endpackage

// File: rtl/dlo_settle.sv
module dlo_settle #(
   parameter int RST_CYCLES = 5
) (
   input  logic clk,
   input  logic rst,
   output logic ready
);
   logic [RST_CYCLES-1:0] fill_q;

   generate
      if (RST_CYCLES < 1) begin : g_bad
         $error("RST_CYCLES must be at least 1");
      end
      if (RST_CYCLES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) fill_q <= 1'b1;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) fill_q <= {fill_q[RST_CYCLES-2:0], 1'b1};
         end
      end
   endgenerate

   assign ready = &fill_q;
endmodule

// File: rtl/dlo_sequencer.sv
module dlo_sequencer
   import dlo_pkg::*;
#(
   parameter int SHORT_BEATS = 1,
   parameter int LONG_BEATS  = 4,
   parameter int ADV_BEATS   = 3
) (
   input  logic clk,
   input  logic clr,
   input  logic grant,
   input  logic grant_len,
   output logic idle,
   output logic accept,
   output len_e cur_len,
   output logic last_beat,
   output logic adv_window
);
   localparam int BW = (LONG_BEATS > 1) ? $clog2(LONG_BEATS) : 1;

   generate
      if (SHORT_BEATS < 1 || SHORT_BEATS >= LONG_BEATS) begin : g_bad_short
         $error("SHORT_BEATS must be at least 1 and below LONG_BEATS");
      end
      if (ADV_BEATS < 1 || ADV_BEATS >= LONG_BEATS) begin : g_bad_adv
         $error("ADV_BEATS must be at least 1 and below LONG_BEATS");
      end
   endgenerate

   logic          active_q;
   len_e          len_q;
   logic [BW-1:0] beat_q;
   logic [BW-1:0] final_beat;

   assign final_beat = (len_q == LEN_LONG) ? BW'(LONG_BEATS - 1) : BW'(SHORT_BEATS - 1);
   assign idle       = !active_q;
   assign accept     = !active_q && grant;
   assign cur_len    = len_q;
   assign last_beat  = active_q && (beat_q == final_beat);
   assign adv_window = active_q && (len_q == LEN_LONG) && (beat_q < BW'(ADV_BEATS));

   always_ff @(posedge clk) begin
      if (clr) begin
         active_q <= 1'b0;
         len_q    <= LEN_SHORT;
         beat_q   <= '0;
      end else if (accept) begin
         active_q <= 1'b1;
         len_q    <= len_e'(grant_len);
         beat_q   <= '0;
      end else if (active_q) begin
         if (last_beat) begin
            active_q <= 1'b0;
            beat_q   <= '0;
         end else begin
            beat_q   <= beat_q + 1'b1;
         end
      end
   end

   AST_SEQ_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (clr)
      last_beat |=> idle);                                              // R2
   AST_SEQ_STEPS_IN_ORDER: assert property (@(posedge clk) disable iff (clr)
      (active_q && !last_beat) |=> (active_q && beat_q == $past(beat_q) + 1'b1)); // R2
endmodule

// File: rtl/dlo_buffer_track.sv
module dlo_buffer_track (
   input  logic clk,
   input  logic clr,
   input  logic arm,
   input  logic accept,
   input  logic len_match,
   input  logic done,
   output logic new_req,
   output logic busy,
   output logic prior
);
   logic busy_q;
   logic prior_q;

   assign new_req = arm && !busy_q;
   assign busy    = busy_q;
   assign prior   = prior_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         busy_q <= 1'b0;
      end else if (new_req) begin
         busy_q <= 1'b1;
      end else if (done && prior_q) begin
         busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         prior_q <= 1'b0;
      end else if (accept) begin
         prior_q <= busy_q && len_match;
      end
   end

   AST_ARM_SETS_BUSY: assert property (@(posedge clk) disable iff (clr)
      (arm && !busy) |=> busy);                                         // R4
   AST_BUSY_DROPS_ON_OWN_DONE: assert property (@(posedge clk) disable iff (clr)
      (!$past(clr) && $fell(busy)) |-> $past(done && prior));           // R7
   AST_BUSY_ARM_IGNORED: assert property (@(posedge clk) disable iff (clr)
      (arm && busy) |-> !new_req);                                      // R10
endmodule

// File: rtl/dlo_request.sv
module dlo_request #(
   parameter int               REQ_W      = 2,
   parameter logic [REQ_W-1:0] CODE_SHORT = 2'd3,
   parameter logic [REQ_W-1:0] CODE_LONG  = 2'd2
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             new_short,
   input  logic             new_long,
   output logic [REQ_W-1:0] req_code
);
   generate
      if (CODE_SHORT == CODE_LONG || CODE_SHORT == '0 || CODE_LONG == '0) begin : g_bad_codes
         $error("request codes must be distinct and non-zero");
      end
   endgenerate

   logic pend_long_q;
   logic long_wants;

   assign long_wants = new_long || pend_long_q;

   always_comb begin
      if (new_short)       req_code = CODE_SHORT;
      else if (long_wants) req_code = CODE_LONG;
      else                 req_code = '0;
   end

   always_ff @(posedge clk) begin
      if (clr) pend_long_q <= 1'b0;
      else     pend_long_q <= new_short && long_wants;
   end

   AST_REQ_CODE_LEGAL: assert property (@(posedge clk) disable iff (clr)
      (req_code == '0) || (req_code == CODE_SHORT) || (req_code == CODE_LONG)); // R4
   AST_LONG_AFTER_SHORT: assert property (@(posedge clk) disable iff (clr)
      (new_short && new_long) |=> (req_code == CODE_LONG));             // R5
endmodule

// File: rtl/dual_len_bus_tx_ctl.sv
module dual_len_bus_tx_ctl
   import dlo_pkg::*;
#(
   parameter int RST_CYCLES  = 5,
   parameter int SHORT_BEATS = 1,
   parameter int LONG_BEATS  = 4,
   parameter int ADV_BEATS   = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       grant,
   input  logic       grant_len,
   input  logic       arm_short,
   input  logic       arm_long,
   output logic [1:0] req_code,
   output logic       hdr_out,
   output logic       sel_hdr,
   output logic       sel_long,
   output logic       short_busy,
   output logic       long_busy,
   output logic       adv_long
);
   localparam int REQ_W = 2;

   logic ready;
   logic clr;
   logic idle;
   logic accept;
   len_e cur_len;
   logic last_beat;
   logic adv_window;

   logic [NUM_BUFS-1:0] arm_v;
   logic [NUM_BUFS-1:0] new_v;
   logic [NUM_BUFS-1:0] busy_v;
   logic [NUM_BUFS-1:0] prior_v;

   dlo_settle #(.RST_CYCLES(RST_CYCLES)) u_settle (
      .clk   (clk),
      .rst   (rst),
      .ready (ready)
   );

   assign clr = rst || !ready;

   dlo_sequencer #(
      .SHORT_BEATS (SHORT_BEATS),
      .LONG_BEATS  (LONG_BEATS),
      .ADV_BEATS   (ADV_BEATS)
   ) u_seq (
      .clk        (clk),
      .clr        (clr),
      .grant      (grant),
      .grant_len  (grant_len),
      .idle       (idle),
      .accept     (accept),
      .cur_len    (cur_len),
      .last_beat  (last_beat),
      .adv_window (adv_window)
   );

   assign arm_v[LEN_SHORT] = arm_short && !clr;
   assign arm_v[LEN_LONG]  = arm_long  && !clr;

   generate
      for (genvar i = 0; i < NUM_BUFS; i++) begin : g_buf
         dlo_buffer_track u_trk (
            .clk       (clk),
            .clr       (clr),
            .arm       (arm_v[i]),
            .accept    (accept),
            .len_match (grant_len == 1'(i)),
            .done      (last_beat && (cur_len == len_e'(i))),
            .new_req   (new_v[i]),
            .busy      (busy_v[i]),
            .prior     (prior_v[i])
         );
      end
   endgenerate

   dlo_request #(
      .REQ_W      (REQ_W),
      .CODE_SHORT (2'd3),
      .CODE_LONG  (2'd2)
   ) u_req (
      .clk       (clk),
      .clr       (clr),
      .new_short (new_v[LEN_SHORT]),
      .new_long  (new_v[LEN_LONG]),
      .req_code  (req_code)
   );

   assign sel_hdr    = idle;
   assign sel_long   = idle ? grant_len : cur_len;
   assign short_busy = busy_v[LEN_SHORT];
   assign long_busy  = busy_v[LEN_LONG];
   assign hdr_out    = !clr && idle && (sel_long ? long_busy : short_busy);
   assign adv_long   = adv_window && prior_v[LEN_LONG];

   AST_HDR_ONLY_IN_IDLE: assert property (@(posedge clk) disable iff (clr)
      hdr_out |-> sel_hdr);                                             // R6
   AST_LEN_HELD_IN_DATA: assert property (@(posedge clk) disable iff (clr)
      (!sel_hdr && $past(!sel_hdr)) |-> $stable(sel_long));             // R3
   AST_ADV_ONLY_LONG_DATA: assert property (@(posedge clk) disable iff (clr)
      adv_long |-> (!sel_hdr && sel_long && long_busy));                // R9
   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) && rst && ready |-> (req_code == 2'd0 && !hdr_out && sel_hdr)); // R1
endmodule

// File: tb/dual_len_bus_tx_ctl_tb_top.sv
module dual_len_bus_tx_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst;
   logic       grant;
   logic       grant_len;
   logic       arm_short;
   logic       arm_long;
   logic [1:0] req_code;
   logic       hdr_out;
   logic       sel_hdr;
   logic       sel_long;
   logic       short_busy;
   logic       long_busy;
   logic       adv_long;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   dual_len_bus_tx_ctl dut_i (
      .clk        (clk),
      .rst        (rst),
      .grant      (grant),
      .grant_len  (grant_len),
      .arm_short  (arm_short),
      .arm_long   (arm_long),
      .req_code   (req_code),
      .hdr_out    (hdr_out),
      .sel_hdr    (sel_hdr),
      .sel_long   (sel_long),
      .short_busy (short_busy),
      .long_busy  (long_busy),
      .adv_long   (adv_long)
   );

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_quiet(string tag);
      chk(tag, "req_code", req_code, 0);
      chk(tag, "hdr_out", hdr_out, 0);
      chk(tag, "sel_hdr", sel_hdr, 1);
      chk(tag, "short_busy", short_busy, 0);
      chk(tag, "long_busy", long_busy, 0);
      chk(tag, "adv_long", adv_long, 0);
   endtask

   task automatic t_reset();
      rst = 1'b1; grant = 1'b1; grant_len = 1'b1; arm_short = 1'b1; arm_long = 1'b1;
      repeat (8) tick();
      settle();
      chk_quiet("R1");
      rst = 1'b0; grant = 1'b0; grant_len = 1'b0; arm_short = 1'b0; arm_long = 1'b0;
      tick(); settle();
      chk_quiet("R1");
   endtask

   task automatic t_idle_len();
      grant_len = 1'b1; settle();
      chk("R3", "sel_long idle", sel_long, 1);
      grant_len = 1'b0; settle();
      chk("R3", "sel_long idle", sel_long, 0);
   endtask

   task automatic t_short_seq();
      grant_len = 1'b0; grant = 1'b1;
      tick(); grant = 1'b0; grant_len = 1'b1; settle();
      chk("R2", "sel_hdr short data", sel_hdr, 0);
      chk("R3", "sel_long held short", sel_long, 0);
      tick(); settle();
      chk("R2", "sel_hdr back idle", sel_hdr, 1);
      chk("R3", "sel_long follows", sel_long, 1);
      grant_len = 1'b0; grant = 1'b1;
      tick(); settle(); chk("R2", "held grant data", sel_hdr, 0);
      tick(); settle(); chk("R2", "held grant idle", sel_hdr, 1);
      tick(); settle(); chk("R2", "held grant data again", sel_hdr, 0);
      grant = 1'b0;
      tick(); settle(); chk("R2", "idle after release", sel_hdr, 1);
   endtask

   task automatic t_long_seq();
      grant_len = 1'b1; grant = 1'b1;
      tick(); grant = 1'b0;
      for (int k = 0; k < 4; k++) begin
         grant_len = k[0];
         settle();
         chk("R2", "sel_hdr long data", sel_hdr, 0);
         chk("R3", "sel_long held long", sel_long, 1);
         chk("R9", "adv_long unarmed", adv_long, 0);
         tick();
      end
      grant_len = 1'b1; settle();
      chk("R2", "idle after four", sel_hdr, 1);
   endtask

   task automatic t_arm_short();
      arm_short = 1'b1; settle();
      chk("R4", "req short", req_code, 3);
      tick(); arm_short = 1'b0; grant_len = 1'b0; settle();
      chk("R4", "short_busy set", short_busy, 1);
      chk("R4", "req back to 0", req_code, 0);
      chk("R6", "hdr_out short sel", hdr_out, 1);
      grant_len = 1'b1; settle();
      chk("R6", "hdr_out long sel", hdr_out, 0);
      arm_short = 1'b1; settle();
      chk("R10", "no req when busy", req_code, 0);
      tick(); arm_short = 1'b0; settle();
      chk("R10", "short_busy kept", short_busy, 1);
      chk("R10", "long_busy untouched", long_busy, 0);
   endtask

   task automatic t_long_keeps_short();
      grant_len = 1'b1; grant = 1'b1;
      tick(); grant = 1'b0;
      for (int k = 0; k < 4; k++) begin
         settle();
         chk("R6", "hdr_out not in data", hdr_out, 0);
         tick();
      end
      settle();
      chk("R7", "short kept by long xfer", short_busy, 1);
      grant_len = 1'b0; grant = 1'b1;
      tick(); grant = 1'b0; settle();
      chk("R7", "short busy in its data", short_busy, 1);
      tick(); settle();
      chk("R7", "short cleared by short xfer", short_busy, 0);
   endtask

   task automatic t_arm_at_grant();
      grant_len = 1'b0; grant = 1'b1; arm_short = 1'b1; settle();
      chk("R4", "req with grant", req_code, 3);
      tick(); grant = 1'b0; arm_short = 1'b0; settle();
      chk("R8", "busy in data", short_busy, 1);
      tick(); settle();
      chk("R8", "not cleared by same xfer", short_busy, 1);
      grant = 1'b1;
      tick(); grant = 1'b0;
      tick(); settle();
      chk("R8", "cleared by next xfer", short_busy, 0);
   endtask

   task automatic t_arm_long_mid();
      grant_len = 1'b1; grant = 1'b1;
      tick(); grant = 1'b0; settle();
      chk("R9", "adv L1 unarmed", adv_long, 0);
      tick(); arm_long = 1'b1; settle();
      chk("R4", "req long", req_code, 2);
      tick(); arm_long = 1'b0; settle();
      chk("R8", "long busy mid xfer", long_busy, 1);
      chk("R9", "adv L3 armed late", adv_long, 0);
      tick(); settle();
      chk("R9", "adv L4 armed late", adv_long, 0);
      tick(); settle();
      chk("R8", "long kept after its xfer", long_busy, 1);
      chk("R6", "hdr_out long ready", hdr_out, 1);
      grant_len = 1'b0; grant = 1'b1;
      tick(); grant = 1'b0;
      tick(); settle();
      chk("R7", "long kept by short xfer", long_busy, 1);
      grant_len = 1'b1; grant = 1'b1;
      tick(); grant = 1'b0;
      for (int k = 0; k < 4; k++) begin
         settle();
         chk("R9", "adv by beat", adv_long, (k < 3) ? 1 : 0);
         tick();
      end
      settle();
      chk("R8", "long cleared by next long", long_busy, 0);
      chk("R9", "adv off in idle", adv_long, 0);
   endtask

   task automatic t_both();
      arm_short = 1'b1; arm_long = 1'b1; settle();
      chk("R5", "first req short", req_code, 3);
      tick(); arm_short = 1'b0; arm_long = 1'b0; settle();
      chk("R5", "second req long", req_code, 2);
      chk("R5", "short busy", short_busy, 1);
      chk("R5", "long busy", long_busy, 1);
      grant_len = 1'b0; settle();
      chk("R6", "hdr both len0", hdr_out, 1);
      grant_len = 1'b1; settle();
      chk("R6", "hdr both len1", hdr_out, 1);
      tick(); settle();
      chk("R5", "req idle after both", req_code, 0);
   endtask

   initial begin
      t_reset();
      t_idle_len();
      t_short_seq();
      t_long_seq();
      t_arm_short();
      t_long_keeps_short();
      t_arm_at_grant();
      t_arm_long_mid();
      t_both();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule